// File: doc/BRIEF.md
# Multi-Mode 16-Cell Function Generator

This block is a small logic element built around one shared array of sixteen single-bit cells. A two-bit mode input, held static in normal use, decides how the array behaves. In table mode the cells hold the truth table of an arbitrary Boolean function of the four address inputs. In memory mode the array is a 16x1 RAM that is written on the clock and read without a clock. In shift mode it is a 16-stage shift register, and the address picks the stage that drives the output.

A wide configuration port replaces all sixteen cells in one clock cycle in any mode. The combinational output always shows the cell picked by the address. It goes to the block's output pin and also to a companion flip-flop that registers it on every clock. The last stage of the array is always brought out on a cascade pin, so that several elements can be chained into a longer shift register. The read path is a balanced binary multiplexer tree with the same depth for every address and every loaded content. Its delay therefore does not depend on the function that is loaded.

Top module: `fg_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all sixteen cells are cleared to 0 and `q_o` is cleared to 0.
- R2: When `cfg_load_i` is high at a rising edge, cell i takes `cfg_data_i[i]` for every i, in any mode. This load takes priority over any write or shift in the same cycle.
- R3: In table mode (`mode_i` = 2'b00, and also 2'b11), `dout_o` equals cell N, where N is the unsigned value of `addr_i`. When all address bits are low, cell 0 is selected.
- R4: In table mode, `we_i` and `din_i` have no effect, and the cells change only through R1 or R2.
- R5: In memory mode (`mode_i` = 2'b01), a rising edge with `we_i` high writes `din_i` into cell `addr_i`. No other cell changes.
- R6: In memory mode, `dout_o` shows cell `addr_i` combinationally. It follows a change of address with no clock edge, and it shows newly written data in the cycle right after the write edge.
- R7: In shift mode (`mode_i` = 2'b10), a rising edge with `we_i` high moves cell i into cell i+1 for i from 0 to 14 and loads `din_i` into cell 0. With `we_i` low, the cells hold.
- R8: In shift mode, `dout_o` equals the stage selected by `addr_i`.
- R9: `cascade_o` always equals cell 15, whatever the mode.
- R10: On every rising edge out of reset, `q_o` takes the value that `dout_o` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Mode: 00/11 table, 01 memory, 10 shift |
| cfg_load_i | input | 1 | Load the whole array from `cfg_data_i` |
| cfg_data_i | input | 16 | Configuration contents, bit i goes to cell i |
| we_i | input | 1 | Write enable (memory) or shift enable (shift) |
| din_i | input | 1 | Write data or shift-in data |
| addr_i | input | 4 | Address / tap select |
| dout_o | output | 1 | Combinational selected cell |
| cascade_o | output | 1 | Last stage of the array |
| q_o | output | 1 | Registered copy of `dout_o` |

## Verification
The bench builds the block with its default four-bit address. This makes all sixteen addresses, the full cascade stage and every tap position small enough to sweep exhaustively after each phase. Directed phases cover reset, a table load followed by writes and shifts that must be ignored, the spare table encoding, memory writes at every address, and shifts with the enable both high and low. A configuration load that collides with a write is also covered. A long pseudo-random run then switches modes and contents every cycle while the bench model follows along.

// File: rtl/fg_pkg.sv
// Package: shared mode encoding and helpers for the function generator.
// Assumes the mode input is two bits wide; the spare code behaves as table mode.
package fg_pkg;

    typedef enum logic [1:0] {
        FG_TABLE     = 2'b00,
        FG_MEMORY    = 2'b01,
        FG_SHIFT     = 2'b10,
        FG_TABLE_ALT = 2'b11
    } fg_mode_e;

    // Decoded per-cycle update operation for the cell array.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_WRITE = 2'b10,
        OP_SHIFT = 2'b11
    } fg_op_e;

    // Picks the array operation; configuration load wins over write/shift.
    function automatic fg_op_e fg_decode(input fg_mode_e mode, input logic load,
                                         input logic en);
        fg_op_e op;
        if (load)
            op = OP_LOAD;
        else if (mode == FG_MEMORY && en)
            op = OP_WRITE;
        else if (mode == FG_SHIFT && en)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/fg_cells.sv
// Module: fg_cells
// Holds the shared cell array and applies one decoded operation per clock:
// whole-array load, single-cell write, or a one-step shift toward the top.
// Assumes the operation has already been prioritised by the caller.
module fg_cells
    import fg_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fg_op_e            op_i,
    input  logic [DEPTH-1:0]  load_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              din_i,
    output logic [DEPTH-1:0]  cells_o
);

    logic [DEPTH-1:0] cells_q;

    // Update the array: reset, load, write, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            unique case (op_i)
                OP_LOAD:  cells_q <= load_data_i;
                OP_WRITE: cells_q[addr_i] <= din_i;
                OP_SHIFT: cells_q <= {cells_q[DEPTH-2:0], din_i};
                default:  cells_q <= cells_q;
            endcase
        end
    end

    assign cells_o = cells_q;

endmodule

// File: rtl/fg_tap_mux.sv
// Module: fg_tap_mux
// Balanced binary multiplexer tree that returns cell[sel]. Every path from the
// array to the output crosses exactly ADDR_W 2:1 stages, so the delay does not
// depend on the stored contents. Assumes cells are ordered with bit 0 at index 0.
module fg_tap_mux #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int NODES = 2 * DEPTH - 1
) (
    input  logic [DEPTH-1:0]  cells_i,
    input  logic [ADDR_W-1:0] sel_i,
    output logic              out_o
);

    // Heap-ordered tree: node 0 is the root, node k has children 2k+1 and 2k+2.
    logic [NODES-1:0] node;

    // Leaves sit at the bottom of the heap in cell order.
    assign node[NODES-1:DEPTH-1] = cells_i;

    // One row of 2:1 selects per address bit, the MSB at the root.
    for (genvar d = 0; d < ADDR_W; d++) begin : g_level
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int K = (1 << d) - 1 + j;
            assign node[K] = sel_i[ADDR_W-1-d] ? node[2*K+2] : node[2*K+1];
        end
    end

    assign out_o = node[0];

endmodule

// File: rtl/fg_out_reg.sv
// Module: fg_out_reg
// The companion flip-flop fed by the generator output; it captures on every
// clock edge and clears on synchronous reset.
module fg_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    // Capture the combinational output each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else
            q_o <= d_i;
    end

endmodule

// File: rtl/fg_cell.sv
// Module: fg_cell (top)
// Multi-mode function generator: one cell array used as a truth table, a 16x1
// RAM or a variable-tap shift register, selected by mode_i. The read is purely
// combinational; a companion register and a cascade output are provided.
// Assumes mode_i is quasi-static; the spare mode code acts as table mode.
module fg_cell
    import fg_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              cfg_load_i,
    input  logic [DEPTH-1:0]  cfg_data_i,
    input  logic              we_i,
    input  logic              din_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              dout_o,
    output logic              cascade_o,
    output logic              q_o
);

    fg_mode_e         mode;
    fg_op_e           op;
    logic [DEPTH-1:0] cells;

    // Decode the mode and pick this cycle's array operation.
    always_comb begin
        mode = fg_mode_e'(mode_i);
        op   = fg_decode(mode, cfg_load_i, we_i);
    end

    fg_cells #(.ADDR_W(ADDR_W)) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .load_data_i (cfg_data_i),
        .addr_i      (addr_i),
        .din_i       (din_i),
        .cells_o     (cells)
    );

    fg_tap_mux #(.ADDR_W(ADDR_W)) u_mux (
        .cells_i (cells),
        .sel_i   (addr_i),
        .out_o   (dout_o)
    );

    fg_out_reg u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dout_o),
        .q_o   (q_o)
    );

    assign cascade_o = cells[DEPTH-1];

endmodule

// File: rtl/fg_cell_chk.sv
// Module: fg_cell_chk
// Property checker for fg_cell, attached with bind. It relates the array state
// to the ports across clock edges.
module fg_cell_chk #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              cfg_load_i,
    input logic [DEPTH-1:0]  cfg_data_i,
    input logic              we_i,
    input logic              din_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              dout_o,
    input logic              cascade_o,
    input logic              q_o,
    input logic [DEPTH-1:0]  cells
);

    logic table_mode;
    assign table_mode = (mode_i == 2'b00) || (mode_i == 2'b11);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cells == '0 && q_o == 1'b0));

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |=> cells == $past(cfg_data_i));

    assert_table_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_o == cells[addr_i]);

    assert_table_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (table_mode && !cfg_load_i) |=> $stable(cells));

    assert_mem_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && we_i && !cfg_load_i) |=> cells[$past(addr_i)] == $past(din_i));

    assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && we_i && !cfg_load_i)
            |=> cells == {$past(cells[DEPTH-2:0]), $past(din_i)});

    assert_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_o == cells[DEPTH-1]);

    assert_out_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> q_o == $past(dout_o));

endmodule

bind fg_cell fg_cell_chk #(.ADDR_W(ADDR_W)) u_fg_cell_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cfg_load_i (cfg_load_i),
    .cfg_data_i (cfg_data_i),
    .we_i       (we_i),
    .din_i      (din_i),
    .addr_i     (addr_i),
    .dout_o     (dout_o),
    .cascade_o  (cascade_o),
    .q_o        (q_o),
    .cells      (cells)
);

// File: tb/tb_fg_cell.sv
`timescale 1ns/1ps
module tb_fg_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        cfg_load_i = 1'b0;
    logic [15:0] cfg_data_i = '0;
    logic        we_i = 1'b0;
    logic        din_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        dout_o, cascade_o, q_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    bit [15:0] ref_cells = '0;
    bit        ref_q = 0;

    always #2.5 clk = ~clk;

    fg_cell dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_load_i(cfg_load_i),
        .cfg_data_i(cfg_data_i), .we_i(we_i), .din_i(din_i), .addr_i(addr_i),
        .dout_o(dout_o), .cascade_o(cascade_o), .q_o(q_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string read_tag(input logic [1:0] m);
        if (m == 2'b01) return "R6";
        if (m == 2'b10) return "R8";
        return "R3";
    endfunction

    // Reference step applied at each rising edge, from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cells = '0;
            ref_q = 0;
        end else begin
            ref_q = ref_cells[addr_i];
            if (cfg_load_i)
                ref_cells = cfg_data_i;
            else if (mode_i == 2'b01 && we_i)
                ref_cells[addr_i] = din_i;
            else if (mode_i == 2'b10 && we_i)
                ref_cells = {ref_cells[14:0], din_i};
        end
    end

    // Drive one cycle of inputs at the falling edge and check the outputs.
    task automatic step(input logic [1:0] m, input logic ld, input logic [15:0] cd,
                        input logic we, input logic d, input logic [3:0] a,
                        input string tag);
        @(negedge clk);
        mode_i = m; cfg_load_i = ld; cfg_data_i = cd; we_i = we; din_i = d; addr_i = a;
        #1;
        if (rst_n) begin
            check((tag == "") ? read_tag(m) : tag, dout_o, ref_cells[a]);
            check("R9", cascade_o, ref_cells[15]);
            check("R10", q_o, ref_q);
        end
    endtask

    // Read every address in the given mode without changing the contents.
    task automatic sweep(input logic [1:0] m, input string tag);
        for (int a = 0; a < 16; a++) step(m, 0, '0, 0, 0, 4'(a), tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with junk on the inputs.
        rst_n = 0;
        step(2'b10, 1, 16'hFFFF, 1, 1, 4'd7, "");
        step(2'b01, 0, 16'h0, 1, 1, 4'd3, "");
        @(negedge clk); rst_n = 1;
        sweep(2'b00, "R1");
        check("R1", q_o, 1'b0);

        // R2/R3: table load, then address N selects bit N.
        step(2'b00, 1, 16'hA5C3, 0, 0, 4'd0, "R2");
        sweep(2'b00, "R3");
        check("R3", dout_o, 1'b1); // last address 15: bit 15 of A5C3 is 1

        // R4: writes and shifts are ignored in table mode, and in the spare code.
        for (int i = 0; i < 20; i++) step(2'b00, 0, '0, 1, i[0], 4'(i), "R4");
        for (int i = 0; i < 20; i++) step(2'b11, 0, '0, 1, ~i[0], 4'(i), "R4");
        sweep(2'b11, "R4");
        check("R4", cascade_o, 1'b1);

        // R5/R6: memory writes at every address, then a read-back sweep.
        for (int a = 0; a < 16; a++) step(2'b01, 0, '0, 1, a[1] ^ a[3], 4'(a), "R5");
        sweep(2'b01, "R6");
        step(2'b01, 0, '0, 1, 1, 4'd9, "R5");
        step(2'b01, 0, '0, 0, 0, 4'd9, "R6");

        // R2: a load collides with a write; the load wins.
        step(2'b01, 1, 16'h0F0F, 1, 1, 4'd15, "R2");
        sweep(2'b01, "R2");

        // R7/R8: shift in a pattern, hold with enable low, check every tap.
        for (int i = 0; i < 16; i++) step(2'b10, 0, '0, 1, (i % 3) == 0, 4'(i), "R7");
        for (int i = 0; i < 5; i++) step(2'b10, 0, '0, 0, 1, 4'(i), "R7");
        sweep(2'b10, "R8");
        for (int i = 0; i < 8; i++) step(2'b10, 0, '0, 1, 1, 4'd15, "R9");

        // Mixed pseudo-random run across all modes.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[1:0], r[31:27] == 0, r[23:8], r[2], r[3], r[7:4], "");
        end

        // R1 again mid-run.
        @(negedge clk); rst_n = 0;
        step(2'b01, 0, '0, 1, 1, 4'd2, "");
        @(negedge clk); rst_n = 1;
        sweep(2'b00, "R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule